// File: doc/BRIEF.md
# Selectable Synchronous Clock Divider Pair

This block takes one fast input clock and derives two divided clocks from it. The first output divides by a small ratio (2 or 4) chosen by one select pin. The second divides by a larger ratio (4 or 6) chosen by another select pin. Each output also comes with its complement. Both dividers advance on the same rising input edges, so any edge the two outputs share falls in exactly the same cycle. Every divided clock has a 50 percent duty cycle, including the divide-by-6 path, which stays high for three input cycles and low for three.

A common active-high `halt` input freezes both dividers at their present levels. It is captured on the falling input edge, so the internal enable only changes while the input clock is low and no shortened pulse can reach the counters. An asynchronous active-high reset clears both dividers so that several copies of the block can be brought into step. A select change is applied only when its divider starts a new period, so a half period is never cut short.

Top module: `sync_clkdiv_pair`

## Requirements
- R1: With `sel_a` low, `div_a` toggles on every enabled rising edge (divide by 2). With `sel_a` high it stays 2 enabled edges high and then 2 low (divide by 4).
- R2: With `sel_b` low, `div_b` stays 2 enabled edges high and then 2 low (divide by 4). With `sel_b` high it stays 3 high and then 3 low (divide by 6).
- R3: Both dividers advance on the same edges. With `sel_a` high and `sel_b` low after a reset, `div_a` and `div_b` are equal in every cycle.
- R4: `halt` is sampled on the falling input edge. A change of `halt` made after that falling edge does not affect the rising edge that follows it.
- R5: When `halt` was high at the last falling edge, the next rising edge leaves all four outputs unchanged.
- R6: While `rst_in` is high, `div_a` and `div_b` are 0 and `div_a_n` and `div_b_n` are 1. This takes effect at once, with no clock edge needed.
- R7: The first enabled rising edge after `rst_in` falls drives both `div_a` and `div_b` high, which starts a fresh period.
- R8: `div_a_n` is the inverse of `div_a` and `div_b_n` is the inverse of `div_b` in every cycle.
- R9: A select input is read only on the rising edge where its divider starts a new period (the output's rising edge). A change in the middle of a period leaves that period's length as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| rst_in | input | 1 | Asynchronous master reset, active high |
| halt | input | 1 | Common freeze, active high, sampled on the falling edge |
| sel_a | input | 1 | Ratio select for the first divider: 0 gives /2, 1 gives /4 |
| sel_b | input | 1 | Ratio select for the second divider: 0 gives /4, 1 gives /6 |
| div_a | output | 1 | First divided clock |
| div_a_n | output | 1 | Complement of `div_a` |
| div_b | output | 1 | Second divided clock |
| div_b_n | output | 1 | Complement of `div_b` |

## Verification
A divider's period wrap can fall on the same rising edge as a freeze that was captured at the falling edge just before it. On that edge the wrap and the select read must both be held off. The bench causes this by raising `halt` and flipping a select in the same random cycles, and it also raises `halt` on purpose in the low phase just before a wrap. The cycle-accurate reference model in the bench judges each case, and a checker property requires that the latched ratio changes only on a rising output edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   // counter width able to hold values 0..max_div
   function automatic int cnt_width(input int max_div);
      return (max_div < 2) ? 1 : $clog2(max_div + 1);
   endfunction

   // ratio chosen for stage idx from the pair of per-stage settings
   function automatic int pick(input int idx, input int first, input int second);
      return (idx == 0) ? first : second;
   endfunction

endpackage

// File: rtl/clkdiv_enable_latch.sv
// Captures the active-high freeze request on the falling input edge so the
// run qualifier only ever changes while the input clock is low.
module clkdiv_enable_latch (
   input  logic clk,
   input  logic rst,
   input  logic halt,
   output logic run
);
   logic run_q;

   always_ff @(negedge clk or posedge rst) begin
      if (rst) run_q <= 1'b0;
      else     run_q <= ~halt;
   end

   assign run = run_q;
endmodule

// File: rtl/clkdiv_stage.sv
// One even-ratio divider with two selectable ratios. The ratio is latched
// only at the start of a period; the output is high for the first half.
module clkdiv_stage #(
   parameter int DIV_LO = 2,
   parameter int DIV_HI = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   input  logic sel,
   output logic q,
   output logic mode
);
   localparam int CW = clkdiv_pkg::cnt_width(DIV_HI);
   localparam logic [CW-1:0] LO_C   = CW'(DIV_LO);
   localparam logic [CW-1:0] HI_C   = CW'(DIV_HI);
   localparam logic [CW-1:0] LO_H   = CW'(DIV_LO / 2);
   localparam logic [CW-1:0] HI_H   = CW'(DIV_HI / 2);
   localparam logic [CW-1:0] ONE_C  = CW'(1);

   generate
      if (DIV_LO < 2 || (DIV_LO % 2) != 0 || (DIV_HI % 2) != 0 || DIV_HI < DIV_LO) begin : g_bad_ratio
         $error("clkdiv_stage: ratios must be even, at least 2, and DIV_HI >= DIV_LO");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          mode_q;
   logic          q_q;
   logic [CW-1:0] cur_div;
   logic [CW-1:0] cur_half;
   logic [CW-1:0] cnt_inc;
   logic          wrap;

   always_comb begin
      cur_div  = mode_q ? HI_C : LO_C;
      cur_half = mode_q ? HI_H : LO_H;
      cnt_inc  = cnt_q + ONE_C;
      wrap     = (cnt_q == '0) || (cnt_q == cur_div);
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cnt_q  <= '0;
         mode_q <= 1'b0;
         q_q    <= 1'b0;
      end else if (run) begin
         if (wrap) begin
            cnt_q  <= ONE_C;
            mode_q <= sel;
            q_q    <= 1'b1;
         end else begin
            cnt_q  <= cnt_inc;
            q_q    <= (cnt_inc <= cur_half);
         end
      end
   end

   assign q    = q_q;
   assign mode = mode_q;
endmodule

// File: rtl/clkdiv_out_pair.sv
// Drives a true/complement output pair from one divided clock.
module clkdiv_out_pair (
   input  logic d,
   output logic q,
   output logic q_n
);
   assign q   = d;
   assign q_n = ~d;
endmodule

// File: rtl/sync_clkdiv_pair.sv
module sync_clkdiv_pair #(
   parameter int A_LO = 2,
   parameter int A_HI = 4,
   parameter int B_LO = 4,
   parameter int B_HI = 6
) (
   input  logic clk_in,
   input  logic rst_in,
   input  logic halt,
   input  logic sel_a,
   input  logic sel_b,
   output logic div_a,
   output logic div_a_n,
   output logic div_b,
   output logic div_b_n
);
   localparam int NSTAGE = 2;

   logic              run_en;
   logic [NSTAGE-1:0] sel_v;
   logic [NSTAGE-1:0] stage_q;
   logic [NSTAGE-1:0] stage_mode;
   logic [NSTAGE-1:0] pos_v;
   logic [NSTAGE-1:0] neg_v;

   assign sel_v = {sel_b, sel_a};

   clkdiv_enable_latch u_en (
      .clk  (clk_in),
      .rst  (rst_in),
      .halt (halt),
      .run  (run_en)
   );

   generate
      for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
         localparam int LO = clkdiv_pkg::pick(g, A_LO, B_LO);
         localparam int HI = clkdiv_pkg::pick(g, A_HI, B_HI);

         clkdiv_stage #(.DIV_LO(LO), .DIV_HI(HI)) u_div (
            .clk  (clk_in),
            .rst  (rst_in),
            .run  (run_en),
            .sel  (sel_v[g]),
            .q    (stage_q[g]),
            .mode (stage_mode[g])
         );

         clkdiv_out_pair u_out (
            .d   (stage_q[g]),
            .q   (pos_v[g]),
            .q_n (neg_v[g])
         );
      end
   endgenerate

   assign div_a   = pos_v[0];
   assign div_a_n = neg_v[0];
   assign div_b   = pos_v[1];
   assign div_b_n = neg_v[1];
endmodule

// File: rtl/sync_clkdiv_pair_chk.sv
module sync_clkdiv_pair_chk #(
   parameter int HALF_A = 2,
   parameter int HALF_B = 3
) (
   input logic       clk_in,
   input logic       rst_in,
   input logic       run_en,
   input logic [1:0] stage_mode,
   input logic       div_a,
   input logic       div_a_n,
   input logic       div_b,
   input logic       div_b_n
);
   logic [7:0] len_a;
   logic [7:0] len_b;
   logic       prev_a;
   logic       prev_b;
   logic       prev_run;

   // length of the current level run, counted in enabled edges
   always_ff @(posedge clk_in or posedge rst_in) begin
      if (rst_in) begin
         len_a    <= 8'd1;
         len_b    <= 8'd1;
         prev_a   <= 1'b0;
         prev_b   <= 1'b0;
         prev_run <= 1'b0;
      end else begin
         prev_a   <= div_a;
         prev_b   <= div_b;
         prev_run <= run_en;
         if (prev_run) begin
            len_a <= (div_a == prev_a) ? len_a + 8'd1 : 8'd1;
            len_b <= (div_b == prev_b) ? len_b + 8'd1 : 8'd1;
         end
      end
   end

   a_r8_complement: assert property (@(posedge clk_in) disable iff (rst_in)
      (div_a_n == ~div_a) && (div_b_n == ~div_b));

   a_r5_hold: assert property (@(posedge clk_in) disable iff (rst_in)
      !$past(run_en) |-> ($stable(div_a) && $stable(div_b)));

   a_r1_half_len: assert property (@(posedge clk_in) disable iff (rst_in)
      len_a <= 8'(HALF_A));

   a_r2_half_len: assert property (@(posedge clk_in) disable iff (rst_in)
      len_b <= 8'(HALF_B));

   a_r6_release_state: assert property (@(posedge clk_in) disable iff (rst_in)
      $fell(rst_in) |-> (!div_a && !div_b && div_a_n && div_b_n));

   a_r7_first_rise: assert property (@(posedge clk_in) disable iff (rst_in)
      ($fell(rst_in) && run_en) |=> (div_a && div_b));

   a_r9_mode_at_wrap_a: assert property (@(posedge clk_in) disable iff (rst_in)
      (!$past(rst_in) && (stage_mode[0] != $past(stage_mode[0]))) |-> $rose(div_a));

   a_r9_mode_at_wrap_b: assert property (@(posedge clk_in) disable iff (rst_in)
      (!$past(rst_in) && (stage_mode[1] != $past(stage_mode[1]))) |-> $rose(div_b));
endmodule

bind sync_clkdiv_pair sync_clkdiv_pair_chk #(.HALF_A(A_HI / 2), .HALF_B(B_HI / 2)) u_chk (
   .clk_in     (clk_in),
   .rst_in     (rst_in),
   .run_en     (run_en),
   .stage_mode (stage_mode),
   .div_a      (div_a),
   .div_a_n    (div_a_n),
   .div_b      (div_b),
   .div_b_n    (div_b_n)
);

// File: tb/test_sync_clkdiv_pair.sv
`timescale 1ns/1ps
module test_sync_clkdiv_pair;
   logic clk_in = 1'b0;
   logic rst_in = 1'b1;
   logic halt   = 1'b0;
   logic sel_a  = 1'b0;
   logic sel_b  = 1'b0;
   logic div_a, div_a_n, div_b, div_b_n;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // reference model state: position in period (0 = fresh) and ratio
   int a_pos = 0, a_div = 2, b_pos = 0, b_div = 4;

   sync_clkdiv_pair i_sync_clkdiv_pair (
      .clk_in (clk_in), .rst_in (rst_in), .halt (halt),
      .sel_a (sel_a), .sel_b (sel_b),
      .div_a (div_a), .div_a_n (div_a_n), .div_b (div_b), .div_b_n (div_b_n)
   );

   always #4 clk_in = ~clk_in;

   task automatic check(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
      end
   endtask

   task automatic adv(inout int pos, inout int dv, input bit s, input int lo, input int hi);
      if (pos == 0 || pos == dv) begin
         dv  = s ? hi : lo;
         pos = 1;
      end else pos++;
   endtask

   function automatic bit lvl(input int pos, input int dv);
      return (pos != 0) && (pos <= dv / 2);
   endfunction

   task automatic compare(input string tag);
      logic [3:0] e, a;
      bit ea, eb;
      ea = lvl(a_pos, a_div);
      eb = lvl(b_pos, b_div);
      e = {ea, ~ea, eb, ~eb};
      a = {div_a, div_a_n, div_b, div_b_n};
      check(a === e, tag, a, e);
   endtask

   // called at rising edge + 1 ns; drives inputs, models the next rising edge
   task automatic step(input bit h, input bit sa, input bit sb, input bit r, input string tag);
      halt = h; sel_a = sa; sel_b = sb; rst_in = r;
      if (r) begin
         #1;
         check({div_a, div_a_n, div_b, div_b_n} === 4'b0101, "R6 async reset",
               {div_a, div_a_n, div_b, div_b_n}, 4'b0101);
         a_pos = 0; b_pos = 0;
      end else if (!h) begin
         adv(a_pos, a_div, sa, 2, 4);
         adv(b_pos, b_div, sb, 4, 6);
      end
      @(posedge clk_in); #1;
      compare(tag);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk_in);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd24681));
      @(posedge clk_in); #1;
      check({div_a, div_a_n, div_b, div_b_n} === 4'b0101, "R6 reset state",
            {div_a, div_a_n, div_b, div_b_n}, 4'b0101);

      // R1 R2 R7: divide by 2 and by 4 from a fresh start
      step(0, 0, 0, 1, "R6");
      step(0, 0, 0, 0, "R7 first edge");
      for (int i = 0; i < 12; i++) step(0, 0, 0, 0, "R1 R2 div2/div4");

      // R2: divide by 6, 3 high 3 low
      step(0, 0, 1, 1, "R6");
      for (int i = 0; i < 18; i++) step(0, 0, 1, 0, "R2 div6");

      // R3: both at divide by 4 must match in every cycle
      step(0, 1, 0, 1, "R6");
      for (int i = 0; i < 16; i++) begin
         step(0, 1, 0, 0, "R3 aligned");
         check(div_a === div_b, "R3 equal", {3'b0, div_a}, {3'b0, div_b});
      end

      // R5: freeze holds all outputs
      for (int i = 0; i < 6; i++) step(1, 1, 0, 0, "R5 hold");
      for (int i = 0; i < 4; i++) step(0, 1, 0, 0, "R5 resume");

      // R9: select flipped mid-period keeps the current period
      step(0, 1, 1, 1, "R6");
      step(0, 1, 1, 0, "R9 start");
      for (int i = 0; i < 14; i++) step(0, 0, 0, 0, "R9 mid-period select");

      // R4: halt raised after the falling edge does not stop the next rising edge
      step(0, 0, 0, 0, "R4 prep");
      @(negedge clk_in); #1;
      halt = 1'b1;
      adv(a_pos, a_div, 1'b0, 2, 4);
      adv(b_pos, b_div, 1'b0, 4, 6);
      @(posedge clk_in); #1;
      compare("R4 late halt ignored");
      step(1, 0, 0, 0, "R4 halt now captured");
      // halt released in the low phase: next rising edge still frozen
      @(negedge clk_in); #1;
      halt = 1'b0;
      @(posedge clk_in); #1;
      compare("R4 late release ignored");
      step(0, 0, 0, 0, "R4 resumed");

      // constrained random mix: freeze, select flips and occasional reset
      for (int i = 0; i < 3000; i++) begin
         bit h, sa, sb, r;
         h  = ($urandom % 6) == 0;
         sa = (($urandom % 12) == 0) ? ~sel_a : sel_a;
         sb = (($urandom % 12) == 0) ? ~sel_b : sel_b;
         r  = ($urandom % 250) == 0;
         step(h, sa, sb, r, h ? "R5 random" : "R1 R2 R9 random");
         check(div_a_n === ~div_a && div_b_n === ~div_b, "R8 complement",
               {div_a, div_a_n, div_b, div_b_n}, {div_a, ~div_a, div_b, ~div_b});
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule